// File: doc/BRIEF.md
# DMA End-of-Block Interrupt Controller

This block sits beside a serial bus peripheral. It holds the end-of-block pending flags for the receive and transmit DMA channels and an 8-bit interrupt mask. It merges every unmasked pending source into a single registered interrupt request. A DMA engine pulses `rx_eob_i` or `tx_eob_i` when it finishes a block. When that happens, the matching flag sets and hardware withdraws the mask bit that enables that DMA channel's request, so the channel stops until software re-arms it. Software reads and writes the mask (address 0) and the flags (address 1) through a one-address-bit register port. Software can only clear a flag.

A peripheral disable input resets the block, but only when it is held long enough. A small state machine watches it. In `ST_RUN` disable is low. The first high cycle moves the machine to `ST_COUNT`, and it counts there while disable stays high. A low cycle in `ST_COUNT` goes back to `ST_RUN`. On the sixth consecutive high cycle it moves to `ST_HELD` and forces the mask and both flags to zero. It stays in `ST_HELD`, forcing, until disable falls, and then returns to `ST_RUN`.

Top module: `dma_eob_irq_ctrl`

## Requirements
- R1: After reset the mask reads 00h, both flags are 0 and `irq_o` is 0.
- R2: A pulse on `rx_eob_i` sets the receive flag (status bit 1) on that clock edge. A pulse on `tx_eob_i` sets the transmit flag (status bit 0) in the same way.
- R3: A write to address 1 with a 0 in bit 1 clears the receive flag, and a 0 in bit 0 clears the transmit flag. A 1 in either bit leaves that flag unchanged.
- R4: If a flag's end-of-block pulse and a software clear of that flag fall in the same cycle, the flag ends up set.
- R5: A receive end-of-block pulse clears mask bit 3 (receive DMA enable). A transmit pulse clears mask bit 0 (transmit DMA enable). This clear wins over a mask write in the same cycle.
- R6: A write to address 0 loads the 8-bit mask. Its bits from 7 down to 0 are: error, transmit-ready, receive-full, arbitration-lost, receive-DMA, data-end, frame-end, transmit-DMA. `rd_data_o` returns the mask at address 0 and {6'b0, rx flag, tx flag} at address 1.
- R7: `irq_o` is the OR over bits of mask AND sources, registered one cycle. The receive flag is ORed into the bit 5 source, and the transmit flag is ORed into the bit 6 source.
- R8: A source whose mask bit is 0 never raises `irq_o`, even when it is pending.
- R9: On the sixth consecutive cycle with `disable_i` high, the mask and both flags become 0. They stay 0 as long as `disable_i` remains high.
- R10: A disable pulse of five cycles or fewer leaves the mask and flags unchanged.
- R11: While the forced clear applies, it wins over end-of-block pulses and mask writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disable_i | input | 1 | Peripheral disable control |
| rx_eob_i | input | 1 | Receive DMA end-of-block pulse |
| tx_eob_i | input | 1 | Transmit DMA end-of-block pulse |
| src_pend_i | input | 8 | Per-bit interrupt source pending, same layout as the mask |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects the mask, 1 selects the flags |
| reg_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `reg_addr_i` |
| mask_o | output | 8 | Mask register contents |
| rx_eob_pend_o | output | 1 | Receive end-of-block flag |
| tx_eob_pend_o | output | 1 | Transmit end-of-block flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check four things on every cycle. An end-of-block pulse sets its flag and drops its DMA mask bit. A write of 1 to a set flag leaves it set. An all-zero mask keeps the request low. The forced clear empties every register on the following edge. Only the bench scenarios show the disable-length threshold: five high cycles change nothing, while the sixth clears. The scenarios also cover the same-cycle collisions between a set and a software clear, and between the forced clear and a set or write, along with the one-cycle request latency. A behavioural model compared on every clock covers the remaining orderings.

// File: rtl/dma_eob_pkg.sv
package dma_eob_pkg;
    localparam int MASK_W      = 8;
    // mask bit positions
    localparam int BIT_ERR     = 7;
    localparam int BIT_TXRDY   = 6;
    localparam int BIT_RXFULL  = 5;
    localparam int BIT_ARBLOST = 4;
    localparam int BIT_RXDMA   = 3;
    localparam int BIT_DATAEND = 2;
    localparam int BIT_FRMEND  = 1;
    localparam int BIT_TXDMA   = 0;
    // status bit positions / channel indices
    localparam int CH_TX       = 0;
    localparam int CH_RX       = 1;
    localparam int NUM_CH      = 2;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_COUNT = 2'd1,
        ST_HELD  = 2'd2
    } dis_state_e;

    typedef enum logic {
        ADDR_MASK   = 1'b0,
        ADDR_STATUS = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/dma_eob_disable_fsm.sv
module dma_eob_disable_fsm #(
    parameter int HOLD_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disable_i,
    output logic force_clr_o
);
    import dma_eob_pkg::*;

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    dis_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (disable_i) begin
                    state_d = ST_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_COUNT: begin
                if (!disable_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_HELD;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_HELD: begin
                if (!disable_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        force_clr_o = 1'b0;
        unique case (state_q)
            ST_RUN:   force_clr_o = 1'b0;
            ST_COUNT: force_clr_o = disable_i && (cnt_q == LAST);
            ST_HELD:  force_clr_o = disable_i;
            default:  force_clr_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_eob_flag.sv
module dma_eob_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic force_clr_i,
    input  logic set_i,
    input  logic sw_clr_i,
    output logic pend_o,
    output logic set_evt_o
);
    logic pend_q;

    // priority: forced clear, then hardware set, then software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pend_q <= 1'b0;
        else if (force_clr_i) pend_q <= 1'b0;
        else if (set_i)       pend_q <= 1'b1;
        else if (sw_clr_i)    pend_q <= 1'b0;
    end

    assign pend_o    = pend_q;
    assign set_evt_o = set_i && !force_clr_i;
endmodule

// File: rtl/dma_eob_mask_reg.sv
module dma_eob_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         force_clr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] hw_clr_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q, mask_d;

    always_comb begin
        mask_d = wr_i ? wdata_i : mask_q;
        mask_d = mask_d & ~hw_clr_i;
        if (force_clr_i) mask_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/dma_eob_irq_merge.sv
module dma_eob_irq_merge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] src_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(mask_i & src_i);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/dma_eob_irq_ctrl.sv
module dma_eob_irq_ctrl #(
    parameter int MASK_W      = dma_eob_pkg::MASK_W,
    parameter int HOLD_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disable_i,
    input  logic              rx_eob_i,
    input  logic              tx_eob_i,
    input  logic [MASK_W-1:0] src_pend_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [MASK_W-1:0] reg_wdata_i,
    output logic [MASK_W-1:0] rd_data_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              rx_eob_pend_o,
    output logic              tx_eob_pend_o,
    output logic              irq_o
);
    import dma_eob_pkg::*;

    logic               force_clr;
    logic [NUM_CH-1:0]  eob_in, sw_clr, pend, set_evt;
    logic [MASK_W-1:0]  hw_clr, eff_src;
    logic               wr_mask, wr_stat;

    assign wr_mask = reg_wr_i && (reg_addr_i == ADDR_MASK);
    assign wr_stat = reg_wr_i && (reg_addr_i == ADDR_STATUS);

    assign eob_in[CH_RX] = rx_eob_i;
    assign eob_in[CH_TX] = tx_eob_i;

    dma_eob_disable_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_dis (
        .clk         (clk),
        .rst_n       (rst_n),
        .disable_i   (disable_i),
        .force_clr_o (force_clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign sw_clr[c] = wr_stat && !reg_wdata_i[c];
        dma_eob_flag u_flag (
            .clk         (clk),
            .rst_n       (rst_n),
            .force_clr_i (force_clr),
            .set_i       (eob_in[c]),
            .sw_clr_i    (sw_clr[c]),
            .pend_o      (pend[c]),
            .set_evt_o   (set_evt[c])
        );
    end

    always_comb begin
        hw_clr            = '0;
        hw_clr[BIT_RXDMA] = set_evt[CH_RX];
        hw_clr[BIT_TXDMA] = set_evt[CH_TX];
    end

    dma_eob_mask_reg #(.W(MASK_W)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_clr_i (force_clr),
        .wr_i        (wr_mask),
        .wdata_i     (reg_wdata_i),
        .hw_clr_i    (hw_clr),
        .mask_o      (mask_o)
    );

    always_comb begin
        eff_src              = src_pend_i;
        eff_src[BIT_RXFULL]  = src_pend_i[BIT_RXFULL] | pend[CH_RX];
        eff_src[BIT_TXRDY]   = src_pend_i[BIT_TXRDY]  | pend[CH_TX];
    end

    dma_eob_irq_merge #(.W(MASK_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (mask_o),
        .src_i  (eff_src),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (reg_addr_i == ADDR_MASK) rd_data_o = mask_o;
        else                         rd_data_o[NUM_CH-1:0] = pend;
    end

    assign rx_eob_pend_o = pend[CH_RX];
    assign tx_eob_pend_o = pend[CH_TX];
endmodule

// File: rtl/dma_eob_irq_checker.sv
module dma_eob_irq_checker #(
    parameter int MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_eob_i,
    input logic              tx_eob_i,
    input logic              reg_wr_i,
    input logic              reg_addr_i,
    input logic [MASK_W-1:0] reg_wdata_i,
    input logic [MASK_W-1:0] mask_o,
    input logic              rx_eob_pend_o,
    input logic              tx_eob_pend_o,
    input logic              irq_o,
    input logic              force_clr
);
    assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eob_i && !force_clr) |=> rx_eob_pend_o);

    assert_tx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_eob_i && !force_clr) |=> tx_eob_pend_o);

    assert_one_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i && reg_wdata_i[1] && rx_eob_pend_o && !force_clr)
        |=> rx_eob_pend_o);

    assert_rxdma_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eob_i && !force_clr) |=> !mask_o[3]);

    assert_txdma_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_eob_i && !force_clr) |=> !mask_o[0]);

    assert_zero_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |=> !irq_o);

    assert_forced_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> (mask_o == '0 && !rx_eob_pend_o && !tx_eob_pend_o));
endmodule

bind dma_eob_irq_ctrl dma_eob_irq_checker #(.MASK_W(MASK_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_eob_i      (rx_eob_i),
    .tx_eob_i      (tx_eob_i),
    .reg_wr_i      (reg_wr_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .mask_o        (mask_o),
    .rx_eob_pend_o (rx_eob_pend_o),
    .tx_eob_pend_o (tx_eob_pend_o),
    .irq_o         (irq_o),
    .force_clr     (force_clr)
);

// File: tb/test_dma_eob_irq_ctrl.sv
module test_dma_eob_irq_ctrl;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dis = 1'b0, rxe = 1'b0, txe = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [7:0] src = '0, wdata = '0;
    logic [7:0] rd_data, mask;
    logic       rxp, txp, irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_eob_irq_ctrl i_dma_eob_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .disable_i(dis), .rx_eob_i(rxe), .tx_eob_i(txe),
        .src_pend_i(src), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .rd_data_o(rd_data), .mask_o(mask), .rx_eob_pend_o(rxp), .tx_eob_pend_o(txp),
        .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_mask = '0;
    logic       m_rx = 1'b0, m_tx = 1'b0, m_irq = 1'b0;
    int         m_run = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '0; m_rx = 0; m_tx = 0; m_irq = 0; m_run = 0;
        end else begin
            logic [7:0] eff;
            logic       frc;
            eff = src;
            eff[5] = eff[5] | m_rx;
            eff[6] = eff[6] | m_tx;
            m_irq = |(m_mask & eff);
            frc = dis && (m_run >= 5);
            m_run = dis ? ((m_run < 6) ? m_run + 1 : 6) : 0;
            if (frc) begin
                m_mask = '0; m_rx = 0; m_tx = 0;
            end else begin
                if (rxe) m_rx = 1;
                else if (wr && addr && !wdata[1]) m_rx = 0;
                if (txe) m_tx = 1;
                else if (wr && addr && !wdata[0]) m_tx = 0;
                if (wr && !addr) m_mask = wdata;
                if (rxe) m_mask[3] = 1'b0;
                if (txe) m_mask[0] = 1'b0;
            end
        end
    end

    // compare on every clock, after the edge has settled
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R5 R6 mask", mask, m_mask);
            chk("R2 R3 R4 rx flag", rxp, m_rx);
            chk("R2 R3 R4 tx flag", txp, m_tx);
            chk("R7 R8 irq", irq, m_irq);
            chk("R6 rd_data", rd_data, addr ? {6'b0, m_rx, m_tx} : m_mask);
        end
    end

    task automatic step(); @(negedge clk); endtask
    task automatic idle();
        rxe = 0; txe = 0; wr = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(); step();
        // R1 reset state
        chk("R1 mask", mask, 0); chk("R1 rx", rxp, 0);
        chk("R1 tx", txp, 0);    chk("R1 irq", irq, 0);
        rst_n = 1; step();

        // R6 mask write and readback
        wr = 1; addr = 0; wdata = 8'hFF; step(); idle(); step();
        chk("R6 readback", rd_data, 8'hFF);

        // R2 rx end-of-block, R5 receive-DMA bit drops
        rxe = 1; step(); idle();
        chk("R2 rx set", rxp, 1);
        chk("R5 rx dma bit", mask, 8'hF7);
        chk("R7 irq not yet", irq, 0);
        step();
        chk("R7 irq after one cycle", irq, 1);

        // R3 writing ones keeps flag, zero clears
        wr = 1; addr = 1; wdata = 8'h03; step(); idle();
        chk("R3 one no effect", rxp, 1);
        wr = 1; addr = 1; wdata = 8'h00; step(); idle();
        chk("R3 zero clears", rxp, 0);

        // R4 set beats clear; R5 tx DMA bit drops despite mask write
        txe = 1; wr = 1; addr = 1; wdata = 8'h00; step(); idle();
        chk("R4 set wins", txp, 1);
        txe = 1; wr = 1; addr = 0; wdata = 8'hFF; step(); idle();
        chk("R5 hw clear beats write", mask, 8'hFE);

        // R8 zero mask blocks all sources
        wr = 1; addr = 0; wdata = 8'h00; step(); idle();
        src = 8'hFF; step(); step();
        chk("R8 masked", irq, 0);
        src = 8'h00;
        // R7 plain source path
        wr = 1; addr = 0; wdata = 8'h80; step(); idle();
        src = 8'h80; step(); step();
        chk("R7 error source", irq, 1);
        src = 8'h00;

        // R10 short disable
        wr = 1; addr = 0; wdata = 8'hA5; step(); idle();
        dis = 1;
        for (int i = 0; i < 5; i++) step();
        dis = 0; step();
        chk("R10 mask kept", mask, 8'hA5);
        chk("R10 tx kept", txp, 1);

        // R9 long disable, R11 forced clear wins while held
        dis = 1;
        for (int i = 0; i < 5; i++) step();
        chk("R10 still kept before sixth", mask, 8'hA5);
        rxe = 1; wr = 1; addr = 0; wdata = 8'h5A; step(); idle();
        chk("R9 mask cleared", mask, 0);
        chk("R9 tx cleared", txp, 0);
        chk("R11 rx set lost", rxp, 0);
        txe = 1; step(); idle();
        chk("R11 held forced", txp, 0);
        dis = 0; step();
        txe = 1; step(); idle();
        chk("R2 set after release", txp, 1);
        step(); step();

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule